// File: doc/BRIEF.md
# Circuit Admission Controller for a Slot-Scheduled Switch

This block keeps the slot accounting for a circuit-switched crossbar with K inputs, K outputs and frames of T slots. For every input/output pair it stores how many slots per frame live circuits use (the used matrix). It also stores a matrix of placeholder slots (the slack matrix). The two together always form a matrix whose rows and columns each sum to exactly T. That property means the pair can always be split into T permutations, one per slot, so the switch never has two packets competing for the same line in the same slot.

Setup and teardown requests name a source and a destination. A teardown turns a used slot back into a placeholder. A setup is admitted only if the source row and the destination column both have spare capacity. If a placeholder already sits at the requested position, the circuit takes it over and the slot schedule does not change. Otherwise two placeholders in the same row and column are swapped toward a third cell. The block reports that the schedule must be rebuilt and names the cell that gained the placeholder.

A combinational query port reads back any cell of either matrix. The scheduling logic downstream uses it, and so does any observer.

Top module: `circuit_admit`

## Requirements
- R1: After reset, the used matrix is all zero. The slack matrix holds T on its diagonal (cell r,r) and zero elsewhere. done_o is low.
- R2: A request sampled with req_valid_i high at a rising edge produces done_o high during the following cycle only. A new request is accepted every cycle. result_o encodes 0 = reject, 1 = local accept, 2 = reconfigure accept.
- R3: A setup (req_op_i = 0) is rejected when used row src already sums to T, or when used column dst already sums to T. A rejected setup leaves both matrices unchanged.
- R4: An admissible setup whose slack cell (src,dst) is nonzero returns local accept. It adds one to used (src,dst) and removes one from slack (src,dst).
- R5: An admissible setup whose slack cell (src,dst) is zero returns reconfigure accept. Let b be the lowest column with slack (src,b) > 0 and a the lowest row with slack (a,dst) > 0. Used (src,dst) gains one, slack (src,b) and slack (a,dst) lose one, and slack (a,b) gains one. mv_row_o = a and mv_col_o = b.
- R6: A teardown (req_op_i = 1) with used (src,dst) > 0 returns local accept. It removes one from used (src,dst) and adds one to slack (src,dst).
- R7: A teardown with used (src,dst) = 0 is rejected and changes nothing.
- R8: At all times every row and every column of used plus slack sums to T, and no line of the used matrix exceeds T.
- R9: qry_used_o and qry_slack_o show the current content of cell (qry_src_i, qry_dst_i) of each matrix, without delay.
- R10: mv_row_o and mv_col_o are zero whenever done_o is low or result_o is not reconfigure accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 1 | 0 = setup, 1 = teardown |
| req_src_i | input | $clog2(K) | Input line of the circuit |
| req_dst_i | input | $clog2(K) | Output line of the circuit |
| done_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 2 | 0 reject, 1 local accept, 2 reconfigure accept |
| mv_row_o | output | $clog2(K) | Row of the cell that gained a placeholder |
| mv_col_o | output | $clog2(K) | Column of the cell that gained a placeholder |
| qry_src_i | input | $clog2(K) | Query row |
| qry_dst_i | input | $clog2(K) | Query column |
| qry_used_o | output | $clog2(T+1) | Used slots at the query cell |
| qry_slack_o | output | $clog2(T+1) | Placeholder slots at the query cell |

## Verification
The hardest state to reach is a reconfigure accept where the chosen row a and column b are not the diagonal cells left by reset. This only happens after earlier swaps have scattered placeholders off the diagonal. It also matters that the lowest-index choice is unambiguous, with several candidates present. The vector table therefore chains swaps, local takeovers and releases so that later reconfigurations pick partners created by earlier ones. Separate directed runs first fill one row and then one column to exactly T, to hit both rejection limits. After every phase, a full sweep of the query port confirms that each line of used plus slack still sums to T.

// File: rtl/circuit_admit_pkg.sv
package circuit_admit_pkg;
  typedef enum logic [1:0] {
    RES_REJECT = 2'd0,
    RES_LOCAL  = 2'd1,
    RES_RECONF = 2'd2
  } adm_res_e;

  typedef enum logic {
    OP_SETUP    = 1'b0,
    OP_TEARDOWN = 1'b1
  } adm_op_e;

  // slack cells touched by one request: at most three
  localparam int NOPS = 3;
endpackage

// File: rtl/adm_pick.sv
module adm_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int n = N - 1; n >= 0; n--) begin
      if (req_i[n]) idx_o = IW'(n);
    end
  end
endmodule

// File: rtl/adm_line_sums.sv
module adm_line_sums #(
  parameter int K = 4,
  parameter int T = 8,
  localparam int IW = (K > 1) ? $clog2(K) : 1,
  localparam int CW = $clog2(T + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            up_i,
  input  logic [IW-1:0]   row_i,
  input  logic [IW-1:0]   col_i,
  output logic [K*CW-1:0] row_sum_o,
  output logic [K*CW-1:0] col_sum_o
);
  for (genvar l = 0; l < K; l++) begin : g_line
    logic [CW-1:0] row_q, col_q;
    logic row_hit, col_hit;

    assign row_hit = en_i && (row_i == IW'(l));
    assign col_hit = en_i && (col_i == IW'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
        col_q <= '0;
      end else begin
        if (row_hit) row_q <= up_i ? row_q + 1'b1 : row_q - 1'b1;
        if (col_hit) col_q <= up_i ? col_q + 1'b1 : col_q - 1'b1;
      end
    end

    assign row_sum_o[l*CW +: CW] = row_q;
    assign col_sum_o[l*CW +: CW] = col_q;

    assert_row_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      row_q <= CW'(T));
    assert_col_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_q <= CW'(T));
    // admission must stop growth at the frame size
    assert_row_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (row_hit && up_i) |-> (row_q < CW'(T)));
    assert_col_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_hit && up_i) |-> (col_q < CW'(T)));
    assert_row_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (row_hit && !up_i) |-> (row_q != '0));
  end
endmodule

// File: rtl/adm_matrix.sv
module adm_matrix
  import circuit_admit_pkg::*;
#(
  parameter int K = 4,
  parameter int T = 8,
  localparam int IW = (K > 1) ? $clog2(K) : 1,
  localparam int CW = $clog2(T + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     f_en_i,
  input  logic                     f_up_i,
  input  logic [IW-1:0]            f_row_i,
  input  logic [IW-1:0]            f_col_i,
  input  logic [NOPS-1:0]          s_en_i,
  input  logic [NOPS-1:0]          s_up_i,
  input  logic [NOPS-1:0][IW-1:0]  s_row_i,
  input  logic [NOPS-1:0][IW-1:0]  s_col_i,
  input  logic [IW-1:0]            rd_row_i,
  input  logic [IW-1:0]            rd_col_i,
  output logic [CW-1:0]            rd_f_o,
  output logic [CW-1:0]            rd_s_o,
  input  logic [IW-1:0]            q_row_i,
  input  logic [IW-1:0]            q_col_i,
  output logic [CW-1:0]            q_f_o,
  output logic [CW-1:0]            q_s_o,
  output logic [K*K-1:0]           s_nz_o
);
  localparam int NC = K * K;

  logic [NC*CW-1:0] f_flat, s_flat;

  for (genvar r = 0; r < K; r++) begin : g_row
    for (genvar c = 0; c < K; c++) begin : g_col
      localparam int ID = r * K + c;
      localparam logic [CW-1:0] S_RST = (r == c) ? CW'(T) : CW'(0);

      logic [CW-1:0]   f_q, s_q, f_nx, s_nx;
      logic [CW+1:0]   s_acc;
      logic            f_hit;

      assign f_hit = f_en_i && (f_row_i == IW'(r)) && (f_col_i == IW'(c));

      always_comb begin
        f_nx = f_q;
        if (f_hit) f_nx = f_up_i ? f_q + 1'b1 : f_q - 1'b1;
      end

      always_comb begin
        s_acc = {2'b00, s_q};
        for (int o = 0; o < NOPS; o++) begin
          if (s_en_i[o] && (s_row_i[o] == IW'(r)) && (s_col_i[o] == IW'(c)))
            s_acc = s_up_i[o] ? s_acc + 1'b1 : s_acc - 1'b1;
        end
        s_nx = s_acc[CW-1:0];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          f_q <= '0;
          s_q <= S_RST;
        end else begin
          f_q <= f_nx;
          s_q <= s_nx;
        end
      end

      assign f_flat[ID*CW +: CW] = f_q;
      assign s_flat[ID*CW +: CW] = s_q;
      assign s_nz_o[ID]          = (s_q != '0);

      assert_cell_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, f_q} + {1'b0, s_q}) <= (CW+1)'(T));
      assert_no_f_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_hit && !f_up_i) |-> (f_q != '0));
      assert_slack_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_acc <= (CW+2)'(T));
    end
  end

  always_comb begin
    int unsigned rd_id, q_id;
    rd_id  = int'(rd_row_i) * K + int'(rd_col_i);
    q_id   = int'(q_row_i) * K + int'(q_col_i);
    rd_f_o = f_flat[rd_id*CW +: CW];
    rd_s_o = s_flat[rd_id*CW +: CW];
    q_f_o  = f_flat[q_id*CW +: CW];
    q_s_o  = s_flat[q_id*CW +: CW];
  end
endmodule

// File: rtl/circuit_admit.sv
module circuit_admit
  import circuit_admit_pkg::*;
#(
  parameter int K = 4,
  parameter int T = 8,
  localparam int IW = (K > 1) ? $clog2(K) : 1,
  localparam int CW = $clog2(T + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_op_i,
  input  logic [IW-1:0] req_src_i,
  input  logic [IW-1:0] req_dst_i,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic [IW-1:0] mv_row_o,
  output logic [IW-1:0] mv_col_o,
  input  logic [IW-1:0] qry_src_i,
  input  logic [IW-1:0] qry_dst_i,
  output logic [CW-1:0] qry_used_o,
  output logic [CW-1:0] qry_slack_o
);
  logic [K*CW-1:0]         row_sum, col_sum;
  logic [K*K-1:0]          s_nz;
  logic [CW-1:0]           f_cur, s_cur;
  logic [K-1:0]            srow_nz, scol_nz;
  logic                    a_found, b_found;
  logic [IW-1:0]           a_idx, b_idx;
  logic                    admit;

  logic                    f_en, f_up;
  logic [NOPS-1:0]         s_en, s_up;
  logic [NOPS-1:0][IW-1:0] s_row, s_col;
  adm_res_e                res_d, res_q;
  logic [IW-1:0]           mv_r_d, mv_c_d, mv_r_q, mv_c_q;
  logic                    done_q;

  adm_matrix #(.K(K), .T(T)) u_matrix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .f_en_i   (f_en),
    .f_up_i   (f_up),
    .f_row_i  (req_src_i),
    .f_col_i  (req_dst_i),
    .s_en_i   (s_en),
    .s_up_i   (s_up),
    .s_row_i  (s_row),
    .s_col_i  (s_col),
    .rd_row_i (req_src_i),
    .rd_col_i (req_dst_i),
    .rd_f_o   (f_cur),
    .rd_s_o   (s_cur),
    .q_row_i  (qry_src_i),
    .q_col_i  (qry_dst_i),
    .q_f_o    (qry_used_o),
    .q_s_o    (qry_slack_o),
    .s_nz_o   (s_nz)
  );

  adm_line_sums #(.K(K), .T(T)) u_sums (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (f_en),
    .up_i      (f_up),
    .row_i     (req_src_i),
    .col_i     (req_dst_i),
    .row_sum_o (row_sum),
    .col_sum_o (col_sum)
  );

  // placeholder positions in the request's row and column
  always_comb begin
    for (int n = 0; n < K; n++) begin
      srow_nz[n] = s_nz[int'(req_src_i) * K + n];
      scol_nz[n] = s_nz[n * K + int'(req_dst_i)];
    end
  end

  adm_pick #(.N(K)) u_pick_col (.req_i(srow_nz), .found_o(b_found), .idx_o(b_idx));
  adm_pick #(.N(K)) u_pick_row (.req_i(scol_nz), .found_o(a_found), .idx_o(a_idx));

  always_comb begin
    admit = (row_sum[int'(req_src_i)*CW +: CW] < CW'(T)) &&
            (col_sum[int'(req_dst_i)*CW +: CW] < CW'(T));
  end

  always_comb begin
    res_d  = RES_REJECT;
    f_en   = 1'b0;
    f_up   = 1'b0;
    s_en   = '0;
    s_up   = '0;
    s_row  = '0;
    s_col  = '0;
    mv_r_d = '0;
    mv_c_d = '0;
    if (req_valid_i) begin
      if (adm_op_e'(req_op_i) == OP_TEARDOWN) begin
        if (f_cur != '0) begin
          res_d    = RES_LOCAL;
          f_en     = 1'b1;
          s_en[0]  = 1'b1;
          s_up[0]  = 1'b1;
          s_row[0] = req_src_i;
          s_col[0] = req_dst_i;
        end
      end else if (admit) begin
        if (s_cur != '0) begin
          res_d    = RES_LOCAL;
          f_en     = 1'b1;
          f_up     = 1'b1;
          s_en[0]  = 1'b1;
          s_row[0] = req_src_i;
          s_col[0] = req_dst_i;
        end else if (a_found && b_found) begin
          // swap: shift placeholders off (src,b) and (a,dst) onto (a,b)
          res_d    = RES_RECONF;
          f_en     = 1'b1;
          f_up     = 1'b1;
          s_en     = 3'b111;
          s_up     = 3'b100;
          s_row[0] = req_src_i;
          s_col[0] = b_idx;
          s_row[1] = a_idx;
          s_col[1] = req_dst_i;
          s_row[2] = a_idx;
          s_col[2] = b_idx;
          mv_r_d   = a_idx;
          mv_c_d   = b_idx;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= RES_REJECT;
      mv_r_q <= '0;
      mv_c_q <= '0;
    end else begin
      done_q <= req_valid_i;
      res_q  <= res_d;
      mv_r_q <= mv_r_d;
      mv_c_q <= mv_c_d;
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
  assign mv_row_o = mv_r_q;
  assign mv_col_o = mv_c_q;

  assert_done_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o);
  assert_reject_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && res_d == RES_REJECT) |=> (row_sum == $past(row_sum) && col_sum == $past(col_sum)));
  // with the perfect-matrix invariant a free row and column always hold a placeholder
  assert_partner_found_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_op_i && admit && s_cur == '0) |-> (a_found && b_found));
  assert_partner_off_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && res_d == RES_RECONF) |=> (mv_row_o != $past(req_src_i) && mv_col_o != $past(req_dst_i)));
  assert_mv_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o || result_o != RES_RECONF) |-> (mv_row_o == '0 && mv_col_o == '0));
endmodule

// File: tb/circuit_admit_bench.sv
`timescale 1ns/1ps
module circuit_admit_bench;
  localparam int K  = 4;
  localparam int T  = 8;
  localparam int IW = 2;
  localparam int CW = 4;
  localparam int NV = 11;

  // {op, src, dst, result, mv_row, mv_col}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd0},
    {1'b0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd0},
    {1'b0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd0},
    {1'b1, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0},
    {1'b0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0},
    {1'b1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0},
    {1'b0, 2'd2, 2'd2, 2'd1, 2'd0, 2'd0},
    {1'b0, 2'd3, 2'd2, 2'd2, 2'd2, 2'd3},
    {1'b0, 2'd2, 2'd3, 2'd1, 2'd0, 2'd0},
    {1'b1, 2'd1, 2'd0, 2'd1, 2'd0, 2'd0},
    {1'b1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0}
  };

  logic          clk, rst_n;
  logic          req_valid, req_op;
  logic [IW-1:0] req_src, req_dst, qry_src, qry_dst, mv_row, mv_col;
  logic          done;
  logic [1:0]    result;
  logic [CW-1:0] qry_used, qry_slack;

  int n_vec, n_bad;
  int mf [K][K];
  int ms [K][K];

  circuit_admit #(.K(K), .T(T)) u_circuit_admit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_src_i(req_src), .req_dst_i(req_dst), .done_o(done), .result_o(result),
    .mv_row_o(mv_row), .mv_col_o(mv_col), .qry_src_i(qry_src), .qry_dst_i(qry_dst),
    .qry_used_o(qry_used), .qry_slack_o(qry_slack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++) begin
        mf[r][c] = 0;
        ms[r][c] = (r == c) ? T : 0;
      end
  endtask

  task automatic model_req(input bit op, input int s, input int d,
                           output int res, output int mr, output int mc);
    int rs, cs, a, b;
    res = 0; mr = 0; mc = 0;
    if (op) begin
      if (mf[s][d] > 0) begin
        mf[s][d]--; ms[s][d]++; res = 1;
      end
    end else begin
      rs = 0; cs = 0;
      for (int n = 0; n < K; n++) begin
        rs += mf[s][n];
        cs += mf[n][d];
      end
      if (rs < T && cs < T) begin
        if (ms[s][d] > 0) begin
          mf[s][d]++; ms[s][d]--; res = 1;
        end else begin
          a = -1; b = -1;
          for (int n = K - 1; n >= 0; n--) begin
            if (ms[n][d] > 0) a = n;
            if (ms[s][n] > 0) b = n;
          end
          mf[s][d]++; ms[s][b]--; ms[a][d]--; ms[a][b]++;
          res = 2; mr = a; mc = b;
        end
      end
    end
  endtask

  // drive on the current falling edge, check one cycle later
  task automatic do_req(input bit op, input int s, input int d,
                        input int er, input int emr, input int emc, input string tag);
    req_valid = 1'b1; req_op = op; req_src = IW'(s); req_dst = IW'(d);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, {tag, " done"}, int'(done), 1);
    chk(int'(result) == er, {tag, " result"}, int'(result), er);
    chk(int'(mv_row) == emr && int'(mv_col) == emc, {tag, " mv_row*4+mv_col R10"},
        int'(mv_row) * 4 + int'(mv_col), emr * 4 + emc);
  endtask

  task automatic model_do(input bit op, input int s, input int d, input string tag);
    int er, emr, emc;
    model_req(op, s, d, er, emr, emc);
    do_req(op, s, d, er, emr, emc, tag);
  endtask

  // R9 cell readback and R8 line sums through the query port
  task automatic sweep(input string tag);
    int rsum [K];
    int csum [K];
    for (int n = 0; n < K; n++) begin rsum[n] = 0; csum[n] = 0; end
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++) begin
        qry_src = IW'(r); qry_dst = IW'(c);
        #1;
        chk(int'(qry_used) == mf[r][c], {tag, " R9 used"}, int'(qry_used), mf[r][c]);
        chk(int'(qry_slack) == ms[r][c], {tag, " R9 slack"}, int'(qry_slack), ms[r][c]);
        rsum[r] += int'(qry_used) + int'(qry_slack);
        csum[c] += int'(qry_used) + int'(qry_slack);
      end
    for (int n = 0; n < K; n++) begin
      chk(rsum[n] == T, {tag, " R8 row sum"}, rsum[n], T);
      chk(csum[n] == T, {tag, " R8 col sum"}, csum[n], T);
    end
  endtask

  function automatic int row_used(input int r);
    int s = 0;
    for (int n = 0; n < K; n++) s += mf[r][n];
    return s;
  endfunction

  function automatic int col_used(input int c);
    int s = 0;
    for (int n = 0; n < K; n++) s += mf[n][c];
    return s;
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int er, emr, emc;
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0;
    req_src = '0; req_dst = '0; qry_src = '0; qry_dst = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    sweep("R1 reset");

    // table: R4 local takeover, R5 swaps, R6 release, R7 empty release
    for (int v = 0; v < NV; v++) begin
      model_req(VEC[v][10], int'(VEC[v][9:8]), int'(VEC[v][7:6]), er, emr, emc);
      do_req(VEC[v][10], int'(VEC[v][9:8]), int'(VEC[v][7:6]),
             int'(VEC[v][5:4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]),
             $sformatf("vec%0d R4/R5/R6/R7", v));
    end
    sweep("table");

    // R3 row limit
    while (row_used(0) < T) model_do(1'b0, 0, 0, "fill row R4");
    do_req(1'b0, 0, 3, 0, 0, 0, "R3 row full reject");
    sweep("R3 row full");

    // R3 column limit
    while (col_used(2) < T) model_do(1'b0, 3, 2, "fill col");
    do_req(1'b0, 1, 2, 0, 0, 0, "R3 col full reject");
    sweep("R3 col full");

    // R2 back-to-back requests
    model_req(1'b1, 0, 0, er, emr, emc);
    req_valid = 1'b1; req_op = 1'b1; req_src = 2'd0; req_dst = 2'd0;
    @(negedge clk);
    chk(done && int'(result) == er, "R2 first of pair", int'(result), er);
    model_req(1'b0, 0, 3, er, emr, emc);
    req_op = 1'b0; req_src = 2'd0; req_dst = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && int'(result) == er, "R2 second of pair", int'(result), er);
    chk(int'(mv_row) == emr && int'(mv_col) == emc, "R2 second mv",
        int'(mv_row) * 4 + int'(mv_col), emr * 4 + emc);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", int'(done), 0);
    sweep("R2 pair");

    // R6 release everything
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++)
        while (mf[r][c] > 0) model_do(1'b1, r, c, "R6 drain");
    do_req(1'b1, 3, 2, 0, 0, 0, "R7 drained reject");
    sweep("R6 drained");

    // R1 reset in the middle of traffic
    model_do(1'b0, 1, 3, "pre-reset R5");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk(done == 1'b0, "R1 done after mid reset", int'(done), 0);
    sweep("R1 mid reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule